// File: doc/BRIEF.md
# Deferred Invalidate Queue with Load Barrier

This block sits between the coherence network and one cache's per-line valid bits. Each invalidate that arrives is acknowledged on the following cycle, whether or not the line has been dropped yet. The line index goes into a small first-in first-out queue. The queue is drained into the valid-bit array one entry per cycle, and only in cycles when the cache port is idle. The port is busy in any cycle in which a load is served or a fill is written.

A load barrier input forces every queued invalidate to be applied before any later load is answered. While the barrier is active, loads are stalled, so the port stays free and the queue drains at full rate. Loads issued without a barrier may still see a line whose invalidate is waiting.

The core can also send outgoing coherence messages, each concerning one line. Such a message is held back while an invalidate for the same line is still queued. A pending-count output reports the queue occupancy.

Top module: `inval_queue_top`

## Requirements
- R1: A request accepted in a cycle (`inv_valid` and `inv_ready` both high) raises `inv_ack` for exactly the next cycle, with `inv_ack_line` equal to the accepted line.
- R2: With `pend_cnt` equal to the queue depth, `inv_ready` is low. A request offered then is neither acknowledged nor queued, and the line it names keeps its valid bit.
- R3: A queued invalidate is never applied in a cycle in which a load fires or a fill is written. A load answered before the invalidate is applied may return a hit for that line.
- R4: In each cycle with a non-empty queue and an idle port, exactly one invalidate is applied, and it is the oldest one. `pend_cnt` then drops by one, unless a new request is accepted in the same cycle, in which case it is unchanged.
- R5: `pend_cnt` always equals the number of accepted invalidates that have not yet been applied.
- R6: `msg_ready` is low while `msg_line` matches any queued invalidate. A message that fires appears on `msg_out_valid` and `msg_out_line` on the next cycle.
- R7: When `ld_barrier` is raised while `pend_cnt` is non-zero, `ld_ready` stays low from that cycle until `pend_cnt` reaches zero. A load waiting behind the barrier therefore sees every earlier invalidate. A barrier raised with an empty queue stalls nothing.
- R8: `fill_valid` sets the valid bit of `fill_line`. A load that fires returns `ld_rvalid` on the next cycle, with `ld_hit` equal to that line's valid bit.
- R9: After reset, all valid bits are clear, `pend_cnt` is zero, `inv_ready` is high and no acknowledgement or response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inv_valid | input | 1 | Invalidate request offered |
| inv_line | input | LINE_W | Line index of the request |
| inv_ready | output | 1 | Queue can take a request |
| inv_ack | output | 1 | Acknowledge of the request accepted last cycle |
| inv_ack_line | output | LINE_W | Line index being acknowledged |
| fill_valid | input | 1 | Write a fill, setting a valid bit |
| fill_line | input | LINE_W | Line being filled |
| ld_valid | input | 1 | Load request |
| ld_line | input | LINE_W | Line read by the load |
| ld_barrier | input | 1 | Load barrier request (one-cycle pulse) |
| ld_ready | output | 1 | Load can be served this cycle |
| ld_rvalid | output | 1 | Load response valid |
| ld_hit | output | 1 | Valid bit of the loaded line |
| msg_valid | input | 1 | Outgoing coherence message offered |
| msg_line | input | LINE_W | Line the message concerns |
| msg_ready | output | 1 | Message may be sent this cycle |
| msg_out_valid | output | 1 | Message forwarded to the network |
| msg_out_line | output | LINE_W | Line of the forwarded message |
| pend_cnt | output | CNT_W | Number of queued invalidates |
| bar_active | output | 1 | Barrier is draining the queue |

## Verification
Two functions can fall in the same cycle: a new request can be accepted in a cycle in which the oldest entry is being applied. The bench provokes this by keeping the port idle while one entry is queued and then offering a second request. It judges the result by `pend_cnt`, which must stay unchanged, and by the acknowledgement, which must still come the next cycle. A barrier raised in the same cycle as a load is also exercised, both with a non-empty queue, where the load must stall until the count reaches zero and then miss, and with an empty queue, where it must be served at once.

// File: rtl/inval_pkg.sv
package inval_pkg;
  localparam int unsigned LINES_DFLT = 16;
  localparam int unsigned DEPTH_DFLT = 4;

  function automatic int unsigned cnt_width(input int unsigned depth);
    return $clog2(depth + 1);
  endfunction

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/inval_fifo.sv
module inval_fifo #(
  parameter int unsigned LINE_W = 4,
  parameter int unsigned DEPTH  = 4,
  localparam int unsigned PTR_W = inval_pkg::idx_width(DEPTH),
  localparam int unsigned CNT_W = inval_pkg::cnt_width(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [LINE_W-1:0] push_line,
  input  logic              pop,
  output logic [LINE_W-1:0] head_line,
  output logic [CNT_W-1:0]  count,
  output logic              full,
  output logic              empty,
  input  logic [LINE_W-1:0] probe_line,
  output logic              probe_hit
);
  logic [LINE_W-1:0] slot_line [DEPTH];
  logic [DEPTH-1:0]  slot_busy;
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [DEPTH-1:0]  hit_vec;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  // storage without reset, one write port
  always_ff @(posedge clk) begin
    if (push) slot_line[wr_ptr] <= push_line;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      count     <= '0;
      slot_busy <= '0;
    end else begin
      if (push) begin
        slot_busy[wr_ptr] <= 1'b1;
        wr_ptr            <= bump(wr_ptr);
      end
      if (pop) begin
        slot_busy[rd_ptr] <= 1'b0;
        rd_ptr            <= bump(rd_ptr);
      end
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  assign head_line = slot_line[rd_ptr];
  assign full      = (count == CNT_W'(DEPTH));
  assign empty     = (count == '0);

  for (genvar g = 0; g < DEPTH; g++) begin : g_probe
    assign hit_vec[g] = slot_busy[g] && (slot_line[g] == probe_line);
  end
  assign probe_hit = |hit_vec;

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
  p_no_underflow_r4: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
  p_count_tracks_r5: assert property (@(posedge clk) disable iff (rst)
    $countones(slot_busy) == int'(count));
endmodule

// File: rtl/inval_vbits.sv
module inval_vbits #(
  parameter int unsigned LINES = 16,
  localparam int unsigned LINE_W = inval_pkg::idx_width(LINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_en,
  input  logic [LINE_W-1:0] set_idx,
  input  logic              clr_en,
  input  logic [LINE_W-1:0] clr_idx,
  input  logic              rd_en,
  input  logic [LINE_W-1:0] rd_idx,
  output logic              rd_valid,
  output logic              rd_hit
);
  logic [LINES-1:0] bits;

  always_ff @(posedge clk) begin
    if (rst) begin
      bits     <= '0;
      rd_valid <= 1'b0;
      rd_hit   <= 1'b0;
    end else begin
      if (clr_en) bits[clr_idx] <= 1'b0;
      if (set_en) bits[set_idx] <= 1'b1;
      rd_valid <= rd_en;
      if (rd_en) rd_hit <= bits[rd_idx];
    end
  end

  // R3: a served load never sees a bit cleared in the same cycle
  p_busy_port_keeps_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !set_en) |=> $stable(bits));
  p_fill_sets_r8: assert property (@(posedge clk) disable iff (rst)
    set_en |=> bits[$past(set_idx)]);
endmodule

// File: rtl/inval_barrier.sv
module inval_barrier (
  input  logic clk,
  input  logic rst,
  input  logic bar_req,
  input  logic cnt_zero,
  input  logic next_zero,
  output logic active,
  output logic ld_block
);
  always_ff @(posedge clk) begin
    if (rst) active <= 1'b0;
    else     active <= (active || bar_req) && !next_zero;
  end

  assign ld_block = active || (bar_req && !cnt_zero);

  p_release_empty_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(active) |-> cnt_zero);
endmodule

// File: rtl/inval_queue_top.sv
module inval_queue_top #(
  parameter int unsigned LINES = inval_pkg::LINES_DFLT,
  parameter int unsigned DEPTH = inval_pkg::DEPTH_DFLT,
  localparam int unsigned LINE_W = inval_pkg::idx_width(LINES),
  localparam int unsigned CNT_W  = inval_pkg::cnt_width(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inv_valid,
  input  logic [LINE_W-1:0] inv_line,
  output logic              inv_ready,
  output logic              inv_ack,
  output logic [LINE_W-1:0] inv_ack_line,
  input  logic              fill_valid,
  input  logic [LINE_W-1:0] fill_line,
  input  logic              ld_valid,
  input  logic [LINE_W-1:0] ld_line,
  input  logic              ld_barrier,
  output logic              ld_ready,
  output logic              ld_rvalid,
  output logic              ld_hit,
  input  logic              msg_valid,
  input  logic [LINE_W-1:0] msg_line,
  output logic              msg_ready,
  output logic              msg_out_valid,
  output logic [LINE_W-1:0] msg_out_line,
  output logic [CNT_W-1:0]  pend_cnt,
  output logic              bar_active
);
  logic              q_push, q_pop, q_full, q_empty, q_probe_hit;
  logic [LINE_W-1:0] q_head;
  logic [CNT_W-1:0]  cnt_next;
  logic              ld_block, ld_fire, port_busy, msg_fire;

  assign inv_ready = !q_full;
  assign q_push    = inv_valid && inv_ready;
  assign ld_ready  = !ld_block;
  assign ld_fire   = ld_valid && ld_ready;
  assign port_busy = ld_fire || fill_valid;
  assign q_pop     = !q_empty && !port_busy;
  assign cnt_next  = pend_cnt + CNT_W'(q_push) - CNT_W'(q_pop);
  assign msg_ready = !q_probe_hit;
  assign msg_fire  = msg_valid && msg_ready;

  inval_fifo #(.LINE_W(LINE_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst),
    .push(q_push), .push_line(inv_line),
    .pop(q_pop), .head_line(q_head),
    .count(pend_cnt), .full(q_full), .empty(q_empty),
    .probe_line(msg_line), .probe_hit(q_probe_hit)
  );

  inval_vbits #(.LINES(LINES)) u_vbits (
    .clk(clk), .rst(rst),
    .set_en(fill_valid), .set_idx(fill_line),
    .clr_en(q_pop), .clr_idx(q_head),
    .rd_en(ld_fire), .rd_idx(ld_line),
    .rd_valid(ld_rvalid), .rd_hit(ld_hit)
  );

  inval_barrier u_bar (
    .clk(clk), .rst(rst),
    .bar_req(ld_barrier),
    .cnt_zero(q_empty),
    .next_zero(cnt_next == '0),
    .active(bar_active),
    .ld_block(ld_block)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      inv_ack       <= 1'b0;
      inv_ack_line  <= '0;
      msg_out_valid <= 1'b0;
      msg_out_line  <= '0;
    end else begin
      inv_ack       <= q_push;
      msg_out_valid <= msg_fire;
      if (q_push)   inv_ack_line <= inv_line;
      if (msg_fire) msg_out_line <= msg_line;
    end
  end

  p_ack_next_r1: assert property (@(posedge clk) disable iff (rst)
    (inv_valid && inv_ready) |=> (inv_ack && inv_ack_line == $past(inv_line)));
  p_full_no_ack_r2: assert property (@(posedge clk) disable iff (rst)
    (inv_valid && !inv_ready) |=> !inv_ack);
  p_count_step_r4: assert property (@(posedge clk) disable iff (rst)
    (!ld_valid && !fill_valid && !inv_valid && pend_cnt != '0)
      |=> pend_cnt == $past(pend_cnt) - CNT_W'(1));
  p_msg_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && q_probe_hit) |=> !msg_out_valid);
  p_barrier_stall_r7: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && bar_active) |=> !ld_rvalid);
endmodule

// File: tb/tb_inval_queue_top.sv
module tb_inval_queue_top;
  localparam int CLK_PERIOD = 10;
  localparam int LINES = 16;
  localparam int DEPTH = 4;
  localparam int LW = 4;
  localparam int CW = 3;

  logic clk = 1'b0;
  logic rst;
  logic inv_valid, fill_valid, ld_valid, ld_barrier, msg_valid;
  logic [LW-1:0] inv_line, fill_line, ld_line, msg_line;
  logic inv_ready, inv_ack, ld_ready, ld_rvalid, ld_hit, msg_ready, msg_out_valid, bar_active;
  logic [LW-1:0] inv_ack_line, msg_out_line;
  logic [CW-1:0] pend_cnt;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  inval_queue_top #(.LINES(LINES), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst),
    .inv_valid(inv_valid), .inv_line(inv_line), .inv_ready(inv_ready),
    .inv_ack(inv_ack), .inv_ack_line(inv_ack_line),
    .fill_valid(fill_valid), .fill_line(fill_line),
    .ld_valid(ld_valid), .ld_line(ld_line), .ld_barrier(ld_barrier),
    .ld_ready(ld_ready), .ld_rvalid(ld_rvalid), .ld_hit(ld_hit),
    .msg_valid(msg_valid), .msg_line(msg_line), .msg_ready(msg_ready),
    .msg_out_valid(msg_out_valid), .msg_out_line(msg_out_line),
    .pend_cnt(pend_cnt), .bar_active(bar_active)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    rst = 1'b1;
    inv_valid = 0; fill_valid = 0; ld_valid = 0; ld_barrier = 0; msg_valid = 0;
    inv_line = '0; fill_line = '0; ld_line = '0; msg_line = '0;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    chk("R9 pend_cnt", int'(pend_cnt), 0);
    chk("R9 inv_ready", int'(inv_ready), 1);
    chk("R9 inv_ack", int'(inv_ack), 0);
    chk("R9 ld_rvalid", int'(ld_rvalid), 0);

    ld_valid = 1; ld_line = 3;
    tick();
    chk("R9 rvalid", int'(ld_rvalid), 1);
    chk("R9 valid bit clear", int'(ld_hit), 0);
    ld_valid = 0;

    // R8: fill every line, then read each back
    fill_valid = 1;
    for (int i = 0; i < LINES; i++) begin
      fill_line = LW'(i);
      tick();
    end
    fill_valid = 0;
    ld_valid = 1;
    for (int i = 0; i < LINES; i++) begin
      ld_line = LW'(i);
      tick();
      chk("R8 rvalid", int'(ld_rvalid), 1);
      chk("R8 hit after fill", int'(ld_hit), 1);
    end

    // R1 R5: port held busy by loads of line 0, queue lines 5..8
    ld_line = 0;
    inv_valid = 1;
    for (int k = 0; k < DEPTH; k++) begin
      inv_line = LW'(5 + k);
      tick();
      chk("R1 ack", int'(inv_ack), 1);
      chk("R1 ack line", int'(inv_ack_line), 5 + k);
      chk("R5 pend_cnt", int'(pend_cnt), k + 1);
      chk("R3 load while busy", int'(ld_hit), 1);
    end
    // R2: full queue
    chk("R2 ready low when full", int'(inv_ready), 0);
    inv_line = 9;
    tick();
    chk("R2 no ack when full", int'(inv_ack), 0);
    chk("R2 count held", int'(pend_cnt), DEPTH);
    inv_valid = 0;
    // R3: stale read of a queued line
    ld_line = 5;
    tick();
    chk("R3 stale hit", int'(ld_hit), 1);
    chk("R3 count unchanged while busy", int'(pend_cnt), DEPTH);

    // R6: messages
    ld_line = 0;
    msg_valid = 1; msg_line = 6;
    #1;
    chk("R6 held for queued line", int'(msg_ready), 0);
    tick();
    chk("R6 no forward", int'(msg_out_valid), 0);
    msg_line = 9;
    #1;
    chk("R6 free line ready", int'(msg_ready), 1);
    tick();
    chk("R6 forwarded", int'(msg_out_valid), 1);
    chk("R6 forwarded line", int'(msg_out_line), 9);
    msg_valid = 0;

    // R4: release the port, drain in arrival order
    ld_valid = 0;
    for (int k = 0; k < DEPTH; k++) begin
      tick();
      chk("R4 drain step", int'(pend_cnt), DEPTH - 1 - k);
      msg_line = LW'(5 + k);
      #1;
      chk("R4 oldest applied", int'(msg_ready), 1);
      if (k < DEPTH - 1) begin
        msg_line = LW'(6 + k);
        #1;
        chk("R4 younger still queued", int'(msg_ready), 0);
      end
    end
    ld_valid = 1;
    for (int i = 4; i <= 9; i++) begin
      ld_line = LW'(i);
      tick();
      chk((i == 9) ? "R2 rejected line untouched" : "R4 applied result",
          int'(ld_hit), (i >= 5 && i <= 8) ? 0 : 1);
    end
    ld_valid = 0;

    // R4 R5: accept and apply in the same cycle
    inv_valid = 1; inv_line = 10;
    tick();
    chk("R5 one queued", int'(pend_cnt), 1);
    inv_line = 11;
    tick();
    chk("R4 push with pop", int'(pend_cnt), 1);
    chk("R1 ack during pop", int'(inv_ack_line), 11);
    inv_valid = 0;
    tick();
    chk("R4 drained", int'(pend_cnt), 0);
    ld_valid = 1;
    ld_line = 10; tick();
    chk("R4 line 10 dropped", int'(ld_hit), 0);
    ld_line = 11; tick();
    chk("R4 line 11 dropped", int'(ld_hit), 0);
    ld_valid = 0;

    // R7: barrier with two queued
    fill_valid = 1;
    fill_line = 1; tick();
    fill_line = 2; tick();
    fill_valid = 0;
    ld_valid = 1; ld_line = 0;
    inv_valid = 1;
    inv_line = 1; tick();
    inv_line = 2; tick();
    inv_valid = 0;
    chk("R5 two queued", int'(pend_cnt), 2);
    ld_line = 1; ld_barrier = 1;
    #1;
    chk("R7 load stalled at barrier", int'(ld_ready), 0);
    tick();
    ld_barrier = 0;
    chk("R7 no response while draining", int'(ld_rvalid), 0);
    chk("R7 barrier active", int'(bar_active), 1);
    begin
      int waited = 0;
      while (!ld_rvalid && waited < 20) begin
        tick();
        waited++;
      end
    end
    chk("R7 load answered", int'(ld_rvalid), 1);
    chk("R7 queue empty at answer", int'(pend_cnt), 0);
    chk("R7 load sees invalidate", int'(ld_hit), 0);
    ld_valid = 0;

    // R7: barrier with an empty queue
    ld_valid = 1; ld_line = 0; ld_barrier = 1;
    #1;
    chk("R7 empty barrier no stall", int'(ld_ready), 1);
    tick();
    ld_barrier = 0; ld_valid = 0;
    chk("R7 served at once", int'(ld_rvalid), 1);
    chk("R7 barrier idle", int'(bar_active), 0);
    tick();
    finish_run();
  end
endmodule